// File: doc/BRIEF.md
# Delta-Sigma Converter Result Reader

This block is the host side of a three-wire read path to a delta-sigma converter: an active-low select, a serial clock and a serial data return. After a `start_i` request it lowers select and watches the data line. While a conversion is still running, the converter holds that line high. Only once the line has gone low does the reader produce 24 serial clock periods. Each period returns one frame bit, most significant bit first.

The frame has four parts. The top bit repeats the conversion-done state, the next bit is a fixed dummy, then comes a sign bit, and the lowest 21 bits carry the result. The reader checks the two leading bits, decodes the sign and the top result bit into over-range and under-range flags, and reports the outcome with a one-cycle pulse. That pulse is `valid_o` for a good frame, `frame_err_o` for a malformed one and `timeout_o` when the conversion never completes.

The serial clock period is set at run time in system clocks. A second run-time value limits how long the reader waits for the conversion to end.

Top module: `adc_frame_reader`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `cs_n_o` is 1, `sck_o` is 0, and `valid_o`, `frame_err_o` and `timeout_o` are 0.
- R2: A `start_i` pulse in idle drives `cs_n_o` low on the next cycle. As long as `sdo_i` stays high, no serial clock edge is produced.
- R3: The serial clock period is max(`div_cfg_i`, 4) system clocks. Each period has a low phase of the period minus half the period (rounded down), then a high phase of half the period (rounded down). `sck_o` is 0 whenever `cs_n_o` is 1.
- R4: A frame has exactly 24 rising serial clock edges. `sdo_i` is captured at each rising edge, and the first captured bit becomes frame bit 23. `code_o` equals frame bits 20..0.
- R5: Frame bit 21 is the sign S and frame bit 20 is the top result bit M. `over_o` = S AND M, and `under_o` = NOT S AND NOT M. Both flags are 0 when S differs from M.
- R6: If frame bit 23 or frame bit 22 is 1, `frame_err_o` pulses instead of `valid_o`, and `code_o`, `over_o` and `under_o` keep their previous values.
- R7: When `sdo_i` remains high for `tmo_cfg_i`+1 consecutive cycles after select goes low, `timeout_o` pulses and `cs_n_o` returns to 1 in the same cycle, with no serial clock edge and no `valid_o`.
- R8: If `sdo_i` goes low in the very cycle in which the timeout would expire, the frame read proceeds and no timeout is reported.
- R9: `cs_n_o` rises in the cycle of the 24th falling serial clock edge, together with a one-cycle `valid_o`. `code_o`, `over_o` and `under_o` hold their values until the next `valid_o`.
- R10: In idle, changes on `sdo_i` have no effect. A `start_i` pulse during a frame neither restarts nor lengthens it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one result read |
| div_cfg_i | input | 8 | Serial clock period in system clocks (values below 4 act as 4) |
| tmo_cfg_i | input | 16 | Conversion wait limit in cycles, minus one |
| sdo_i | input | 1 | Serial data from the converter (reads high while released) |
| cs_n_o | output | 1 | Active-low converter select |
| sck_o | output | 1 | Serial clock, low while idle |
| code_o | output | 21 | Last good 21-bit result |
| over_o | output | 1 | Last good result at or above positive full scale |
| under_o | output | 1 | Last good result below negative full scale |
| valid_o | output | 1 | One-cycle pulse: new result on `code_o` and flags |
| frame_err_o | output | 1 | One-cycle pulse: frame rejected by its leading bits |
| timeout_o | output | 1 | One-cycle pulse: conversion did not finish in time |

## Verification
Two events can land in the same cycle: the conversion-done level on the data line and expiry of the wait limit. The bench device model holds the line high for a set number of cycles after select falls. With that busy time equal to the limit, both events fall on one edge, and the read must run to a valid result with no timeout. With a busy time one cycle longer, only the timeout may appear, with select released and no clock edge. Serial clock edges and periods are counted at the pins in both cases.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_WAIT  = 2'd1,
        RD_SHIFT = 2'd2
    } rd_state_e;

    localparam int unsigned MIN_SCK_PERIOD = 4;

endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] period,
    output logic             sck,
    output logic             rise,
    output logic             fall
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sck;
    } gen_regs_t;

    gen_regs_t r_d, r_q;
    logic [DIV_W-1:0] low_len;
    logic [DIV_W-1:0] last_cnt;

    assign low_len  = period - (period >> 1);
    assign last_cnt = period - 1'b1;

    always_comb begin
        r_d = r_q;
        if (!run) begin
            r_d.cnt = '0;
            r_d.sck = 1'b0;
        end else begin
            if (r_q.cnt == last_cnt) begin
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
            r_d.sck = (r_d.cnt >= low_len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sck  = r_q.sck;
    assign rise = !r_q.sck && r_d.sck;
    assign fall = r_q.sck && !r_d.sck;

endmodule

// File: rtl/adc_eoc_timer.sv
module adc_eoc_timer #(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (!expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_frame_decode.sv
module adc_frame_decode #(
    parameter int unsigned FRAME_W = 24,
    parameter int unsigned CODE_W  = 21
) (
    input  logic [FRAME_W-1:0] frame,
    output logic [CODE_W-1:0]  code,
    output logic               over,
    output logic               under,
    output logic               bad
);

    localparam int unsigned DONE_POS = FRAME_W - 1;
    localparam int unsigned PAD_POS  = FRAME_W - 2;
    localparam int unsigned SIGN_POS = FRAME_W - 3;
    localparam int unsigned TOP_POS  = CODE_W - 1;

    logic sign_b, top_b;

    assign sign_b = frame[SIGN_POS];
    assign top_b  = frame[TOP_POS];
    assign code   = frame[CODE_W-1:0];
    assign over   = sign_b && top_b;
    assign under  = !sign_b && !top_b;
    assign bad    = frame[DONE_POS] || frame[PAD_POS];

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int unsigned FRAME_W = 24,
    parameter int unsigned CODE_W  = 21,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned TMO_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  div_cfg_i,
    input  logic [TMO_W-1:0]  tmo_cfg_i,
    input  logic              sdo_i,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic [CODE_W-1:0] code_o,
    output logic              over_o,
    output logic              under_o,
    output logic              valid_o,
    output logic              frame_err_o,
    output logic              timeout_o
);

    localparam int unsigned BCNT_W = $clog2(FRAME_W + 1);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_W);
    localparam logic [DIV_W-1:0] MIN_PER = DIV_W'(MIN_SCK_PERIOD);

    typedef struct packed {
        rd_state_e          state;
        logic               cs_n;
        logic [BCNT_W-1:0]  bits;
        logic [FRAME_W-1:0] shreg;
        logic [CODE_W-1:0]  code;
        logic               over;
        logic               under;
        logic               valid;
        logic               ferr;
        logic               tmo;
    } rd_regs_t;

    rd_regs_t r_d, r_q;

    logic [DIV_W-1:0]  period;
    logic              sck_rise, sck_fall, sck_line;
    logic              wait_expired;
    logic [CODE_W-1:0] dec_code;
    logic              dec_over, dec_under, dec_bad;

    assign period = (div_cfg_i < MIN_PER) ? MIN_PER : div_cfg_i;

    adc_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk    (clk),
        .rst    (rst),
        .run    (r_q.state == RD_SHIFT),
        .period (period),
        .sck    (sck_line),
        .rise   (sck_rise),
        .fall   (sck_fall)
    );

    adc_eoc_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (r_q.state != RD_WAIT),
        .limit   (tmo_cfg_i),
        .expired (wait_expired)
    );

    adc_frame_decode #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_dec (
        .frame (r_q.shreg),
        .code  (dec_code),
        .over  (dec_over),
        .under (dec_under),
        .bad   (dec_bad)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.ferr  = 1'b0;
        r_d.tmo   = 1'b0;
        unique case (r_q.state)
            RD_IDLE: begin
                r_d.cs_n = 1'b1;
                if (start_i) begin
                    r_d.state = RD_WAIT;
                    r_d.cs_n  = 1'b0;
                    r_d.bits  = '0;
                    r_d.shreg = '0;
                end
            end
            RD_WAIT: begin
                // a completed conversion outranks an expiring wait
                if (!sdo_i) begin
                    r_d.state = RD_SHIFT;
                end else if (wait_expired) begin
                    r_d.state = RD_IDLE;
                    r_d.cs_n  = 1'b1;
                    r_d.tmo   = 1'b1;
                end
            end
            RD_SHIFT: begin
                if (sck_rise) begin
                    r_d.shreg = {r_q.shreg[FRAME_W-2:0], sdo_i};
                    r_d.bits  = r_q.bits + 1'b1;
                end
                if (sck_fall && (r_q.bits == LAST_BIT)) begin
                    r_d.state = RD_IDLE;
                    r_d.cs_n  = 1'b1;
                    if (dec_bad) begin
                        r_d.ferr = 1'b1;
                    end else begin
                        r_d.valid = 1'b1;
                        r_d.code  = dec_code;
                        r_d.over  = dec_over;
                        r_d.under = dec_under;
                    end
                end
            end
            default: begin
                r_d.state = RD_IDLE;
                r_d.cs_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.state <= RD_IDLE;
            r_q.cs_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o      = r_q.cs_n;
    assign sck_o       = sck_line;
    assign code_o      = r_q.code;
    assign over_o      = r_q.over;
    assign under_o     = r_q.under;
    assign valid_o     = r_q.valid;
    assign frame_err_o = r_q.ferr;
    assign timeout_o   = r_q.tmo;

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
    parameter int unsigned CODE_W = 21
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n_o,
    input logic              sck_o,
    input logic [CODE_W-1:0] code_o,
    input logic              over_o,
    input logic              under_o,
    input logic              valid_o,
    input logic              frame_err_o,
    input logic              timeout_o
);

    AST_SCK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sck_o); // R3

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && frame_err_o)); // R6

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R9

    AST_RELEASE_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
        (valid_o || frame_err_o) |-> cs_n_o); // R9

    AST_RANGE_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !(over_o && under_o)); // R5

    AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (cs_n_o && !sck_o && !$past(sck_o))); // R7

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_o) |-> valid_o); // R9

endmodule

bind adc_frame_reader adc_frame_reader_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n_o      (cs_n_o),
    .sck_o       (sck_o),
    .code_o      (code_o),
    .over_o      (over_o),
    .under_o     (under_o),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o),
    .timeout_o   (timeout_o)
);

// File: tb/adc_frame_reader_test.sv
`timescale 1ns/1ps
module adc_frame_reader_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  div_cfg_i = 8'd4;
    logic [15:0] tmo_cfg_i = 16'd200;
    logic        sdo_i;
    logic        cs_n_o, sck_o, over_o, under_o, valid_o, frame_err_o, timeout_o;
    logic [20:0] code_o;

    always #4 clk = ~clk;

    adc_frame_reader uut (
        .clk(clk), .rst(rst), .start_i(start_i), .div_cfg_i(div_cfg_i),
        .tmo_cfg_i(tmo_cfg_i), .sdo_i(sdo_i), .cs_n_o(cs_n_o), .sck_o(sck_o),
        .code_o(code_o), .over_o(over_o), .under_o(under_o), .valid_o(valid_o),
        .frame_err_o(frame_err_o), .timeout_o(timeout_o)
    );

    int tests = 0;
    int fails = 0;

    // converter model and pin monitor, both evaluated at the falling system edge
    logic [23:0] dev_word = '0;
    int          dev_busy = 0;
    int          dev_idx = 0;
    logic        dev_sdo = 1'b1;
    logic        dprev = 1'b0;
    logic        ovr_en = 1'b0;
    logic        ovr_val = 1'b1;
    int          cyc = 0;
    int          rises = 0;
    int          last_rise = 0;
    int          per = 0;
    int          nvalid = 0;

    assign sdo_i = ovr_en ? ovr_val : dev_sdo;

    always @(negedge clk) begin
        cyc++;
        if (cs_n_o) begin
            dev_sdo = 1'b1;
            dev_idx = 0;
        end else if (dev_busy != 0) begin
            dev_busy--;
            dev_sdo = 1'b1;
        end else begin
            if (dprev && !sck_o) dev_idx++;
            dev_sdo = (dev_idx >= 24) ? 1'b1 : dev_word[23 - dev_idx];
        end
        if (sck_o && !dprev) begin
            rises++;
            if (rises == 2) per = cyc - last_rise;
            last_rise = cyc;
        end
        if (valid_o) nvalid++;
        dprev = sck_o;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // outcome codes: 1 valid, 2 frame error, 3 timeout, 0 none
    int res_kind;
    logic [20:0] res_code;
    logic res_over, res_under, res_csn;

    task automatic run_read(input logic [23:0] w, input logic [7:0] d,
                            input int busy, input logic [15:0] tmo);
        step();
        dev_word  = w;
        dev_busy  = busy;
        div_cfg_i = d;
        tmo_cfg_i = tmo;
        rises = 0;
        per = 0;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        res_kind = 0;
        for (int i = 0; i < 4000; i++) begin
            if (valid_o || frame_err_o || timeout_o) begin
                res_kind  = valid_o ? 1 : (frame_err_o ? 2 : 3);
                res_code  = code_o;
                res_over  = over_o;
                res_under = under_o;
                res_csn   = cs_n_o;
                break;
            end
            step();
        end
    endtask

    localparam int NV = 8;
    localparam logic [23:0] VW [NV] = '{24'h300000, 24'h2FFFFF, 24'h200000, 24'h1FFFFF,
                                       24'h100000, 24'h0FFFFF, 24'h6ABCDE, 24'h2A5A5A};
    localparam logic [7:0]  VD [NV] = '{8'd4, 8'd5, 8'd7, 8'd4, 8'd9, 8'd2, 8'd6, 8'd3};
    // expected {over, under, frame error}
    localparam logic [2:0]  VX [NV] = '{3'b100, 3'b000, 3'b000, 3'b000,
                                       3'b000, 3'b010, 3'b001, 3'b000};

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [20:0] prev_code;
        int exp_per;
        int v0;
        repeat (3) step();
        chk(cs_n_o && !sck_o && !valid_o && !frame_err_o && !timeout_o, "R1 in reset",
            {cs_n_o, sck_o, valid_o, frame_err_o, timeout_o}, 5'b10000);
        rst = 1'b0;
        step();
        chk(cs_n_o && !sck_o && !valid_o && !frame_err_o && !timeout_o, "R1 after reset",
            {cs_n_o, sck_o, valid_o, frame_err_o, timeout_o}, 5'b10000);

        // vector table
        prev_code = code_o;
        for (int k = 0; k < NV; k++) begin
            run_read(VW[k], VD[k], 3 + k, 16'd300);
            exp_per = (VD[k] < 4) ? 4 : int'(VD[k]);
            chk(res_kind == (VX[k][0] ? 2 : 1), "R6 outcome kind", res_kind, VX[k][0] ? 2 : 1);
            chk(rises == 24, "R4 rising edges", rises, 24);
            chk(per == exp_per, "R3 sck period", per, exp_per);
            chk(res_csn == 1'b1, "R9 select released", res_csn, 1);
            if (!VX[k][0]) begin
                chk(res_code == VW[k][20:0], "R4 code", res_code, VW[k][20:0]);
                chk({res_over, res_under} == VX[k][2:1], "R5 range flags",
                    {res_over, res_under}, VX[k][2:1]);
                prev_code = res_code;
            end else begin
                chk(res_code == prev_code, "R6 code kept on error", res_code, prev_code);
            end
        end

        // R9 result holds after the pulse
        repeat (20) step();
        chk(code_o == prev_code && !valid_o, "R9 result held", code_o, prev_code);

        // R10 idle ignores the data line
        ovr_en = 1'b1;
        ovr_val = 1'b0;
        v0 = nvalid;
        rises = 0;
        repeat (20) step();
        chk(cs_n_o && rises == 0 && nvalid == v0, "R10 idle data ignored", rises, 0);
        ovr_en = 1'b0;
        step();

        // R2 wait while converter busy, no clock
        step();
        dev_word = 24'h2ABCDE;
        dev_busy = 40;
        tmo_cfg_i = 16'd100;
        div_cfg_i = 8'd4;
        rises = 0;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        chk(!cs_n_o, "R2 select low", cs_n_o, 0);
        repeat (20) step();
        chk(!cs_n_o && rises == 0 && !sck_o, "R2 no clock while busy", rises, 0);
        // R10 start during a frame changes nothing
        v0 = nvalid;
        for (int i = 0; i < 600 && !valid_o; i++) begin
            if (rises == 10) start_i = 1'b1;
            step();
            start_i = 1'b0;
        end
        chk(rises == 24 && code_o == 21'h0ABCDE, "R10 restart ignored", rises, 24);
        repeat (30) step();
        chk(nvalid == v0 + 1 && cs_n_o, "R10 single result", nvalid - v0, 1);

        // R7 timeout: busy one cycle longer than the wait window
        v0 = nvalid;
        run_read(24'h212345, 8'd4, 11, 16'd10);
        chk(res_kind == 3, "R7 timeout reported", res_kind, 3);
        chk(res_csn && rises == 0 && nvalid == v0, "R7 released without clock", rises, 0);
        repeat (5) step();

        // R8 conversion done in the expiry cycle wins
        run_read(24'h254321, 8'd5, 10, 16'd10);
        chk(res_kind == 1, "R8 done beats timeout", res_kind, 1);
        chk(res_code == 21'h054321, "R8 code", res_code, 21'h054321);

        // R1 reset in the middle of a frame
        step();
        dev_word = 24'h211111;
        dev_busy = 2;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        repeat (30) step();
        rst = 1'b1;
        step();
        step();
        chk(cs_n_o && !sck_o && !valid_o, "R1 reset mid-frame", {cs_n_o, sck_o}, 2'b10);
        rst = 1'b0;
        repeat (3) step();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule